// File: doc/BRIEF.md
# Keyed Sector Guard Register Unit

This unit keeps one guard bit per 4 KB flash sector and one chip-erase lock byte. A decoded command-frame stream comes in from a serial front end. Each frame has a start pulse that carries the opcode, an address-present flag and a 24-bit address. Zero or more data-byte pulses follow, and an end pulse closes the frame. The unit watches this stream for two key sequences. One restores the guard map to all ones. The other clears chosen guard bits. A frame that breaks a sequence drops the tracker back to idle, and nothing changes.

The array write path asks the unit whether a sector may be written. The unit looks up the guard bit of the queried sector and combines it with the block-protect decision supplied by the caller. A guarded sector is refused even when the block-protect decision would allow the write. A separate read opcode loads a byte pointer into the register file. The front end then consumes bytes one by one and serialises each byte, MSB first. Storage and erase timing are modelled with flops and a busy counter.

Top module: `sector_guard`

## Requirements
- R1: After reset, every register byte (offsets 0 to 8) reads FFh, busy is 0, no sector is guarded and chipEraseBlock is 0.
- R2: Sector n is guarded exactly when bit (n mod 8) of register byte n/8 is 0; sectGuarded reports this for qrySector.
- R3: writeDenied is 1 whenever sectGuarded is 1, regardless of bpProtected, and also whenever bpProtected is 1; it is 0 only when both are 0.
- R4: Five consecutive frames 55h, AAh, 80h, AAh (each with an address and no data) and then 2Bh (no address, no data) set every register byte, including byte 8, to FFh.
- R5: Four consecutive frames 55h, AAh, A0h, 55h (each with an address and no data) followed by a 23h frame with an address and 1 to 256 data bytes program the registers. Data byte k targets offset (addr + k) mod 16. Offsets 9 to 15 are discarded. Each targeted byte becomes its old value AND the data.
- R6: A frame that does not match the next expected step returns the tracker to idle and changes nothing. The step is judged by opcode, by address presence and by data count, and a 23h frame with 0 or more than 256 data bytes counts as wrong.
- R7: A completed erase or program raises busy on the next cycle for exactly BUSY_CYCLES cycles. A frame that ends while busy changes no register and resets the tracker.
- R8: Opcode 2Fh with an address loads the read pointer with the address modulo 16. rdData shows the byte at the pointer, and each rdNext pulse advances it, wrapping from 15 to 0. Offsets 9 to 15 read FFh. Reads also work while busy.
- R9: chipEraseBlock is 1 whenever register byte 8 differs from FFh.
- R10: Register bytes change only on the cycle after a frame end, and never while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frmStart | input | 1 | Frame header strobe |
| frmOpcode | input | 8 | Opcode of the frame, valid with frmStart |
| frmHasAddr | input | 1 | Frame carries an address, valid with frmStart |
| frmAddr | input | 24 | Frame address, valid with frmStart |
| dataValid | input | 1 | One data byte of the current frame |
| dataByte | input | 8 | Data byte, valid with dataValid |
| frmEnd | input | 1 | Frame end strobe |
| rdNext | input | 1 | Advance the read pointer by one byte |
| rdData | output | 8 | Register byte at the read pointer |
| qrySector | input | 6 | Sector index to look up |
| bpProtected | input | 1 | Block-protect decision for the queried sector |
| sectGuarded | output | 1 | Queried sector is guarded |
| writeDenied | output | 1 | Write to the queried sector must be refused |
| chipEraseBlock | output | 1 | Chip erase must be refused |
| busy | output | 1 | Erase or program in progress |

## Verification
The assertions assume a well-formed frame stream. frmEnd never shares a cycle with frmStart, data pulses appear only between the two strobes, and frames do not overlap. Under those assumptions, register contents can move only after an end strobe while idle. The bench keeps within this: every strobe is a single-cycle pulse driven on the falling clock edge, each frame task issues start, data and end in strict order, and the bench waits for busy to clear before it expects a sequence to take effect.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam logic [7:0] OP_KEY_A   = 8'h55;
  localparam logic [7:0] OP_KEY_B   = 8'hAA;
  localparam logic [7:0] OP_KEY_ERS = 8'h80;
  localparam logic [7:0] OP_KEY_PRG = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h2B;
  localparam logic [7:0] OP_PROG    = 8'h23;
  localparam logic [7:0] OP_READ    = 8'h2F;

  typedef enum logic [2:0] {
    TRK_IDLE, TRK_K1, TRK_K2, TRK_E3, TRK_E4, TRK_P3, TRK_P4
  } trk_e;

  typedef struct packed {
    logic eraseAll;
    logic commit;
    logic stageInit;
    logic stageByte;
    logic rdLoad;
    logic rdInc;
  } sgCtl_t;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int BUSY_CYCLES = 40,
  parameter int MAX_DATA    = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frmStart,
  input  logic [7:0] frmOpcode,
  input  logic       frmHasAddr,
  input  logic       dataValid,
  input  logic       frmEnd,
  input  logic       rdNext,
  output sgCtl_t     ctl,
  output logic       busy
);
  localparam int CNT_W  = $clog2(MAX_DATA + 2);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0]  DATA_LIM  = CNT_W'(MAX_DATA);
  localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(MAX_DATA + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  trk_e              state, nxtState;
  logic [7:0]        curOp;
  logic              curHasAddr;
  logic              inFrame;
  logic [CNT_W-1:0]  dataCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              keyFrame;
  logic              progFrame;

  assign busy      = (busyCnt != '0);
  assign keyFrame  = inFrame && curHasAddr && (dataCnt == '0);
  assign progFrame = inFrame && (state == TRK_P4) && (curOp == OP_PROG) && curHasAddr;

  always_comb begin
    nxtState = state;
    if (frmEnd && inFrame) begin
      nxtState = TRK_IDLE;
      if (!busy) begin
        case (state)
          TRK_IDLE: if (keyFrame && curOp == OP_KEY_A) nxtState = TRK_K1;
          TRK_K1:   if (keyFrame && curOp == OP_KEY_B) nxtState = TRK_K2;
          TRK_K2: begin
            if (keyFrame && curOp == OP_KEY_ERS)      nxtState = TRK_E3;
            else if (keyFrame && curOp == OP_KEY_PRG) nxtState = TRK_P3;
          end
          TRK_E3:   if (keyFrame && curOp == OP_KEY_B) nxtState = TRK_E4;
          TRK_P3:   if (keyFrame && curOp == OP_KEY_A) nxtState = TRK_P4;
          default:  nxtState = TRK_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctl.stageInit = frmStart && !busy && (state == TRK_P4) &&
                    (frmOpcode == OP_PROG) && frmHasAddr;
    ctl.stageByte = dataValid && !busy && progFrame && (dataCnt < DATA_LIM);
    ctl.commit    = frmEnd && !busy && progFrame &&
                    (dataCnt != '0) && (dataCnt <= DATA_LIM);
    ctl.eraseAll  = frmEnd && inFrame && !busy && (state == TRK_E4) &&
                    (curOp == OP_ERASE) && !curHasAddr && (dataCnt == '0);
    ctl.rdLoad    = frmStart && (frmOpcode == OP_READ) && frmHasAddr;
    ctl.rdInc     = rdNext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= TRK_IDLE;
      curOp      <= '0;
      curHasAddr <= 1'b0;
      inFrame    <= 1'b0;
      dataCnt    <= '0;
      busyCnt    <= '0;
    end else begin
      state <= nxtState;
      if (frmStart) begin
        inFrame    <= 1'b1;
        curOp      <= frmOpcode;
        curHasAddr <= frmHasAddr;
        dataCnt    <= '0;
      end else if (frmEnd) begin
        inFrame <= 1'b0;
      end else if (dataValid && inFrame && dataCnt != CNT_SAT) begin
        dataCnt <= dataCnt + 1'b1;
      end
      if (ctl.commit || ctl.eraseAll) busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0)         busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/sg_data.sv
module sg_data
  import sg_pkg::*;
#(
  parameter int SECTORS   = 64,
  parameter int REG_BYTES = 9,
  parameter int PTR_W     = 4,
  parameter int SECT_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  sgCtl_t                 ctl,
  input  logic [23:0]            frmAddr,
  input  logic [7:0]             dataByte,
  input  logic [SECT_W-1:0]      qrySector,
  output logic [7:0]             rdData,
  output logic                   sectGuarded,
  output logic [7:0]             ceByte,
  output logic [REG_BYTES*8-1:0] regFlat
);
  localparam int GUARD_BYTES = SECTORS / 8;
  localparam int SEL_W       = SECT_W - 3;

  logic [REG_BYTES*8-1:0] stageFlat;
  logic [PTR_W-1:0]       wrPtr, rdPtr;
  logic [7:0]             guardByte;

  for (genvar g = 0; g < REG_BYTES; g++) begin : gByte
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    logic [7:0] memB, stgB;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        memB <= 8'hFF;
        stgB <= 8'hFF;
      end else begin
        if (ctl.eraseAll)    memB <= 8'hFF;
        else if (ctl.commit) memB <= memB & stgB;
        if (ctl.stageInit)                         stgB <= 8'hFF;
        else if (ctl.stageByte && wrPtr == IDX)    stgB <= stgB & dataByte;
      end
    end
    assign regFlat[g*8 +: 8]   = memB;
    assign stageFlat[g*8 +: 8] = stgB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.stageInit)      wrPtr <= frmAddr[PTR_W-1:0];
      else if (ctl.stageByte) wrPtr <= wrPtr + 1'b1;
      if (ctl.rdLoad)         rdPtr <= frmAddr[PTR_W-1:0];
      else if (ctl.rdInc)     rdPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    rdData = 8'hFF;
    for (int i = 0; i < REG_BYTES; i++)
      if (rdPtr == PTR_W'(i)) rdData = regFlat[i*8 +: 8];
  end

  always_comb begin
    guardByte = 8'hFF;
    for (int i = 0; i < GUARD_BYTES; i++)
      if (qrySector[SECT_W-1:3] == SEL_W'(i)) guardByte = regFlat[i*8 +: 8];
  end

  assign sectGuarded = ~guardByte[qrySector[2:0]];
  assign ceByte      = regFlat[GUARD_BYTES*8 +: 8];
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int SECTORS     = 64,
  parameter int BUSY_CYCLES = 40,
  parameter int MAX_DATA    = 256,
  localparam int GUARD_BYTES = SECTORS / 8,
  localparam int REG_BYTES   = GUARD_BYTES + 1,
  localparam int PTR_W       = $clog2(REG_BYTES),
  localparam int SECT_W      = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frmStart,
  input  logic [7:0]        frmOpcode,
  input  logic              frmHasAddr,
  input  logic [23:0]       frmAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              frmEnd,
  input  logic              rdNext,
  output logic [7:0]        rdData,
  input  logic [SECT_W-1:0] qrySector,
  input  logic              bpProtected,
  output logic              sectGuarded,
  output logic              writeDenied,
  output logic              chipEraseBlock,
  output logic              busy
);
  sgCtl_t                 ctl;
  logic [7:0]             ceByte;
  logic [REG_BYTES*8-1:0] regFlat;

  sg_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .MAX_DATA(MAX_DATA)) uCtrl (
    .clk(clk), .rst_n(rst_n), .frmStart(frmStart), .frmOpcode(frmOpcode),
    .frmHasAddr(frmHasAddr), .dataValid(dataValid), .frmEnd(frmEnd),
    .rdNext(rdNext), .ctl(ctl), .busy(busy)
  );

  sg_data #(.SECTORS(SECTORS), .REG_BYTES(REG_BYTES), .PTR_W(PTR_W), .SECT_W(SECT_W)) uData (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .frmAddr(frmAddr), .dataByte(dataByte),
    .qrySector(qrySector), .rdData(rdData), .sectGuarded(sectGuarded),
    .ceByte(ceByte), .regFlat(regFlat)
  );

  assign writeDenied    = sectGuarded | bpProtected;
  assign chipEraseBlock = ~&ceByte;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int BUSY_CYCLES = 40,
  parameter int FLAT_W      = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frmEnd,
  input logic              busy,
  input logic              sectGuarded,
  input logic              bpProtected,
  input logic              writeDenied,
  input logic [FLAT_W-1:0] regFlat
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_EXP = RUN_W'(BUSY_CYCLES);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BUSY_CYCLES + 1);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rst_n)                        runLen <= '0;
    else if (!busy)                    runLen <= '0;
    else if (runLen != RUN_MAX)        runLen <= runLen + 1'b1;
  end

  AST_GUARD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sectGuarded |-> writeDenied); // R3
  AST_BP_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    bpProtected |-> writeDenied); // R3
  AST_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frmEnd) |-> $stable(regFlat)); // R10
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(regFlat)); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frmEnd)); // R7
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> runLen == RUN_EXP); // R7
endmodule

bind sector_guard sg_checker #(.BUSY_CYCLES(BUSY_CYCLES), .FLAT_W(REG_BYTES*8)) uChk (
  .clk(clk), .rst_n(rst_n), .frmEnd(frmEnd), .busy(busy),
  .sectGuarded(sectGuarded), .bpProtected(bpProtected),
  .writeDenied(writeDenied), .regFlat(regFlat)
);

// File: tb/sector_guard_test.sv
module sector_guard_test;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frmStart = 1'b0;
  logic [7:0]  frmOpcode = '0;
  logic        frmHasAddr = 1'b0;
  logic [23:0] frmAddr = '0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic        frmEnd = 1'b0;
  logic        rdNext = 1'b0;
  logic [7:0]  rdData;
  logic [5:0]  qrySector = '0;
  logic        bpProtected = 1'b0;
  logic        sectGuarded, writeDenied, chipEraseBlock, busy;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [0:8];
  logic [7:0] pBuf [0:299];

  always #2.5 clk = ~clk;

  sector_guard #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .frmStart(frmStart), .frmOpcode(frmOpcode),
    .frmHasAddr(frmHasAddr), .frmAddr(frmAddr), .dataValid(dataValid),
    .dataByte(dataByte), .frmEnd(frmEnd), .rdNext(rdNext), .rdData(rdData),
    .qrySector(qrySector), .bpProtected(bpProtected), .sectGuarded(sectGuarded),
    .writeDenied(writeDenied), .chipEraseBlock(chipEraseBlock), .busy(busy)
  );

  function automatic logic [7:0] expAt(input logic [3:0] off);
    return (off < 4'd9) ? mdl[off] : 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] op, input logic ha, input logic [23:0] ad, input int n);
    @(negedge clk);
    frmStart = 1'b1; frmOpcode = op; frmHasAddr = ha; frmAddr = ad;
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1'b1; dataByte = pBuf[i % 300];
      @(negedge clk);
    end
    dataValid = 1'b0;
    frmEnd = 1'b1;
    @(negedge clk);
    frmEnd = 1'b0;
  endtask

  task automatic progKeys();
    sendFrame(8'h55, 1'b1, 24'h000100, 0);
    sendFrame(8'hAA, 1'b1, 24'h000200, 0);
    sendFrame(8'hA0, 1'b1, 24'h000300, 0);
    sendFrame(8'h55, 1'b1, 24'h000400, 0);
  endtask

  task automatic modelProg(input logic [3:0] start, input int n);
    logic [3:0] p = start;
    for (int i = 0; i < n; i++) begin
      if (p < 4'd9) mdl[p] = mdl[p] & pBuf[i];
      p = p + 4'd1;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic readCheck(input logic [3:0] start, input int n, input string tag);
    logic [3:0] p = start;
    @(negedge clk);
    frmStart = 1'b1; frmOpcode = 8'h2F; frmHasAddr = 1'b1; frmAddr = {20'hABCDE, start};
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      check(tag, rdData, expAt(p));
      rdNext = 1'b1;
      @(negedge clk);
      rdNext = 1'b0;
      p = p + 4'd1;
    end
    frmEnd = 1'b1;
    @(negedge clk);
    frmEnd = 1'b0;
  endtask

  task automatic qCheck(input logic [5:0] s, input logic bp, input string tag);
    logic g;
    qrySector = s; bpProtected = bp;
    #1;
    g = ~mdl[s[5:3]][s[2:0]];
    check({tag, " guard"}, {7'd0, sectGuarded}, {7'd0, g});
    check({tag, " deny"}, {7'd0, writeDenied}, {7'd0, g | bp});
    bpProtected = 1'b0;
  endtask

  task automatic tReset();
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 ceBlock", {7'd0, chipEraseBlock}, 8'd0);
    readCheck(4'd0, 16, "R1 R8 reset readback");
    qCheck(6'd0, 1'b0, "R1 sector0");
  endtask

  task automatic tProgramBasic();
    int cnt = 0;
    pBuf[0] = 8'hFE; pBuf[1] = 8'h7F;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h000000, 2);
    modelProg(4'd0, 2);
    while (busy) begin cnt++; @(negedge clk); end
    check("R7 busy length", 8'(cnt), 8'(BUSY));
    readCheck(4'd0, 9, "R5 program");
    qCheck(6'd0, 1'b0, "R2 R3 sector0");
    qCheck(6'd15, 1'b0, "R2 sector15");
    qCheck(6'd1, 1'b0, "R2 sector1");
  endtask

  task automatic tProgramAnd();
    pBuf[0] = 8'hFF; pBuf[1] = 8'hFD;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h000000, 2);
    modelProg(4'd0, 2);
    waitIdle();
    readCheck(4'd0, 2, "R5 and-merge");
    pBuf[0] = 8'h00; pBuf[1] = 8'hEF;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h00000F, 2);
    modelProg(4'd15, 2);
    waitIdle();
    readCheck(4'd0, 9, "R5 pointer wrap");
  endtask

  task automatic tBadSeq();
    pBuf[0] = 8'h00;
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'hA0, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'h23, 1'b1, 24'h0, 1);
    check("R6 wrong key busy", {7'd0, busy}, 8'd0);
    sendFrame(8'h55, 1'b0, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'hA0, 1'b1, 24'h0, 0);
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    sendFrame(8'h23, 1'b1, 24'h0, 1);
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h0, 0);
    check("R6 zero data busy", {7'd0, busy}, 8'd0);
    for (int i = 0; i < 300; i++) pBuf[i] = 8'h00;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h0, 257);
    check("R6 overlong busy", {7'd0, busy}, 8'd0);
    readCheck(4'd0, 9, "R6 unchanged");
  endtask

  task automatic tBusyIgnore();
    pBuf[0] = 8'hF0;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h000002, 1);
    modelProg(4'd2, 1);
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    check("R7 still busy", {7'd0, busy}, 8'd1);
    readCheck(4'd1, 3, "R8 read while busy");
    waitIdle();
    pBuf[0] = 8'h00;
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'hA0, 1'b1, 24'h0, 0);
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    sendFrame(8'h23, 1'b1, 24'h000002, 1);
    check("R7 key in busy dropped", {7'd0, busy}, 8'd0);
    readCheck(4'd2, 1, "R7 byte2 kept");
  endtask

  task automatic tChipLock();
    pBuf[0] = 8'hFE;
    progKeys();
    sendFrame(8'h23, 1'b1, 24'h000008, 1);
    modelProg(4'd8, 1);
    waitIdle();
    check("R9 ceBlock set", {7'd0, chipEraseBlock}, 8'd1);
    readCheck(4'd7, 4, "R8 read across end");
  endtask

  task automatic tErase();
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'h80, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'h2B, 1'b1, 24'h0, 0);
    check("R6 erase with addr busy", {7'd0, busy}, 8'd0);
    readCheck(4'd0, 9, "R6 erase rejected");
    sendFrame(8'h55, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'h80, 1'b1, 24'h0, 0);
    sendFrame(8'hAA, 1'b1, 24'h0, 0);
    sendFrame(8'h2B, 1'b0, 24'h0, 0);
    check("R4 erase busy", {7'd0, busy}, 8'd1);
    for (int i = 0; i < 9; i++) mdl[i] = 8'hFF;
    waitIdle();
    readCheck(4'd0, 9, "R4 erased");
    check("R9 ceBlock clear", {7'd0, chipEraseBlock}, 8'd0);
  endtask

  task automatic tBlockProtect();
    qCheck(6'd63, 1'b1, "R3 bp only");
    qCheck(6'd63, 1'b0, "R3 open");
  endtask

  initial begin
    for (int i = 0; i < 9; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < 300; i++) pBuf[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tProgramBasic();
    tProgramAnd();
    tBadSeq();
    tBusyIgnore();
    tChipLock();
    tErase();
    tBlockProtect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule